// File: doc/BRIEF.md
# Accumulator Output Field Selector

This block takes the 36-bit result of a multiply-accumulate array and reduces it to a 24-bit output word. A 2-bit selection code chooses which 24-bit window of the result is kept. The kept field is rounded by adding half of its least significant bit and is then sign-extended to 32 bits. A test override ignores the selection code. It takes result bits 22 down to 0 and appends a zero below them, so the whole word moves up by one place. The 32-bit word is read as two 16-bit read-only halves.

The block watches for range loss. When the rounded field cannot represent the full value, which includes the case of a carry out of rounding, a selector-overflow event is raised. A second error source comes in as a level from an external cascade adder. Each source has an error bit with an arm/clear protocol. Writing 1 arms the bit. Writing 0 clears and disarms it. The adder bit refuses to clear while the adder still signals overflow. An active-low error pin is low while any error bit is set.

Top module: `acc_field_select`

## Requirements
- R1: After reset `res_lo` and `res_hi` are 0, `err_flags` is 0 and `err_n` is 1.
- R2: With `full_test` low, `sel_code` value k selects the field whose LSB is result bit 4*k, for k = 0, 1, 2 and 3. Bits above bit 35 are copies of bit 35. The rounded field appears on `res_lo`/`res_hi` one clock after the cycle in which `acc_valid` is high.
- R3: For k > 0 the field is rounded by adding result bit 4*k-1. For k = 0 no rounding is applied. A carry past the field's top bit wraps the 24-bit output and does not saturate it.
- R4: With `full_test` high the field is result bits 22..0 shifted up by one place with a zero in bit 0. No rounding is applied, and `sel_code` is ignored.
- R5: `res_lo` holds output bits 15..0 of the 24-bit field. `res_hi[7:0]` holds field bits 23..16. `res_hi[15:8]` are copies of field bit 23.
- R6: A selector-overflow event occurs when the rounded value does not fit a signed 24-bit field. If `err_flags[0]` is armed, that event sets it on the same edge that loads the result.
- R7: While `err_flags[0]` is unarmed, an overflowing result leaves it at 0.
- R8: If `err_flags[1]` is armed, a high `adder_ovf` sets it on the next edge.
- R9: A cycle with `ctl_wr` high writes `ctl_wdata`. A 1 arms the bit. A 0 clears and disarms it. For bit 1, a write of 0 has no effect while `adder_ovf` is high.
- R10: `err_n` is 0 exactly while some bit of `err_flags` is 1.
- R11: While `acc_valid` is low, `res_lo` and `res_hi` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_in | input | 36 | Accumulator result, two's complement |
| acc_valid | input | 1 | Load a new result this cycle |
| sel_code | input | 2 | Field selection code |
| full_test | input | 1 | Test override of field selection |
| adder_ovf | input | 1 | Overflow level from the cascade adder |
| ctl_wr | input | 1 | Write strobe for the error bits |
| ctl_wdata | input | 2 | Arm (1) or clear (0) value per error bit; bit 0 selector, bit 1 adder |
| res_lo | output | 16 | Output word bits 15..0 |
| res_hi | output | 16 | Output word bits 31..16, sign-extended |
| err_flags | output | 2 | Error bits; bit 0 selector overflow, bit 1 adder overflow |
| err_n | output | 1 | Active-low error pin |

## Verification
On every cycle, the assertions check the following: the error pin agrees with the error bits, and the result registers hold between loads. They also check that the upper byte of the high half copies the sign. Each error bit may rise only after its own cause, and the adder bit cannot drop while the adder still reports overflow. Only the bench scenarios show the actual field arithmetic: the window position for each code, half-LSB rounding, the wrapping carry and the test-override shift. The scenarios also cover the arm/clear sequence, including the unarmed case, where an overflow must leave no trace.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int ERR_N   = 2;
  localparam int ERR_SEL = 0;
  localparam int ERR_ADD = 1;
endpackage

// File: rtl/fsel_round.sv
// Window selection, half-LSB rounding and range check (combinational).
module fsel_round #(
  parameter int ACC_W   = 36,
  parameter int FIELD_W = 24,
  parameter int SEL_W   = 2,
  parameter int STEP    = 4
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic [SEL_W-1:0]   sel,
  input  logic               test,
  output logic [FIELD_W-1:0] field,
  output logic               ovf
);
  localparam int EXT_W = ACC_W + 2;
  localparam int IDX_W = $clog2(EXT_W + 1);
  localparam int TOP_W = EXT_W - FIELD_W + 1;

  logic signed [EXT_W-1:0] ext;
  logic        [EXT_W:0]   ext_lo;   // ext with a zero below bit 0
  logic        [IDX_W-1:0] sh;
  logic signed [EXT_W-1:0] base;
  logic                    rnd;
  logic        [EXT_W-1:0] sum;
  logic        [TOP_W-1:0] top;

  assign ext    = {{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc};
  assign ext_lo = {ext, 1'b0};
  assign sh     = IDX_W'(int'(sel) * STEP);

  always_comb begin
    if (test) begin
      base = ext <<< 1;
      rnd  = 1'b0;
    end else begin
      base = ext >>> sh;
      rnd  = ext_lo[sh];          // bit sh-1 of the result, 0 when sh is 0
    end
    sum = base + {{(EXT_W-1){1'b0}}, rnd};
  end

  assign field = sum[FIELD_W-1:0];
  assign top   = sum[EXT_W-1:FIELD_W-1];
  assign ovf   = !((&top) || (~|top));
endmodule

// File: rtl/fsel_errbit.sv
// One armable error bit; HOLD_EN blocks clearing while hold is high.
module fsel_errbit #(
  parameter bit HOLD_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic evt,
  input  logic hold,
  output logic flag
);
  logic armed;
  logic clr_ok;

  assign clr_ok = !(HOLD_EN && hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      flag  <= 1'b0;
    end else if (wr) begin
      if (wdata) begin
        armed <= 1'b1;
      end else if (clr_ok) begin
        armed <= 1'b0;
        flag  <= 1'b0;
      end
    end else if (armed && evt) begin
      flag <= 1'b1;
    end
  end
endmodule

// File: rtl/fsel_outreg.sv
// Holds the field and presents it sign-extended as REG_W-bit words.
module fsel_outreg #(
  parameter int FIELD_W = 24,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] field,
  output logic [REG_W-1:0]   lo,
  output logic [REG_W-1:0]   hi
);
  localparam int OUT_W = 2 * REG_W;

  logic [FIELD_W-1:0]     field_q;
  logic [OUT_W-1:0]       word;
  logic [1:0][REG_W-1:0]  words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    field_q <= '0;
    else if (load) field_q <= field;
  end

  assign word = {{(OUT_W-FIELD_W){field_q[FIELD_W-1]}}, field_q};

  for (genvar g = 0; g < 2; g++) begin : g_words
    assign words[g] = word[g*REG_W +: REG_W];
  end

  assign lo = words[0];
  assign hi = words[1];
endmodule

// File: rtl/acc_field_select.sv
module acc_field_select
  import fsel_pkg::*;
#(
  parameter int ACC_W   = 36,
  parameter int FIELD_W = 24,
  parameter int SEL_W   = 2,
  parameter int STEP    = 4,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   acc_in,
  input  logic               acc_valid,
  input  logic [SEL_W-1:0]   sel_code,
  input  logic               full_test,
  input  logic               adder_ovf,
  input  logic               ctl_wr,
  input  logic [ERR_N-1:0]   ctl_wdata,
  output logic [REG_W-1:0]   res_lo,
  output logic [REG_W-1:0]   res_hi,
  output logic [ERR_N-1:0]   err_flags,
  output logic               err_n
);
  logic [FIELD_W-1:0] field;
  logic               sel_ovf_evt;   // range loss of the current result
  logic [ERR_N-1:0]   err_evt;
  logic [ERR_N-1:0]   err_hold;

  fsel_round #(
    .ACC_W(ACC_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W), .STEP(STEP)
  ) u_round (
    .acc(acc_in), .sel(sel_code), .test(full_test),
    .field(field), .ovf(sel_ovf_evt)
  );

  fsel_outreg #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(acc_valid), .field(field),
    .lo(res_lo), .hi(res_hi)
  );

  assign err_evt[ERR_SEL]  = acc_valid && sel_ovf_evt;
  assign err_hold[ERR_SEL] = 1'b0;
  assign err_evt[ERR_ADD]  = adder_ovf;
  assign err_hold[ERR_ADD] = adder_ovf;

  for (genvar e = 0; e < ERR_N; e++) begin : g_err
    fsel_errbit #(.HOLD_EN(e == ERR_ADD)) u_bit (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata[e]),
      .evt(err_evt[e]), .hold(err_hold[e]), .flag(err_flags[e])
    );
  end

  assign err_n = ~|err_flags;
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
  import fsel_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             adder_ovf,
  input logic             sel_ovf_evt,
  input logic [REG_W-1:0] res_lo,
  input logic [REG_W-1:0] res_hi,
  input logic [ERR_N-1:0] err_flags,
  input logic             err_n
);
  // R10
  err_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |-> !err_n);
  // R10
  err_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags == '0) |-> err_n);
  // R6
  sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_SEL]) |-> $past(acc_valid && sel_ovf_evt));
  // R8
  add_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_ADD]) |-> $past(adder_ovf));
  // R9
  add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[ERR_ADD] && adder_ovf) |=> err_flags[ERR_ADD]);
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(res_lo) && $stable(res_hi)));
  // R5
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi[REG_W-1:REG_W/2] == {(REG_W/2){res_hi[REG_W/2-1]}});
endmodule

bind acc_field_select fsel_chk #(.REG_W(REG_W)) u_fsel_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .adder_ovf(adder_ovf),
  .sel_ovf_evt(sel_ovf_evt), .res_lo(res_lo), .res_hi(res_hi),
  .err_flags(err_flags), .err_n(err_n)
);

// File: tb/test_acc_field_select.sv
module test_acc_field_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] acc_in = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  sel_code = '0;
  logic        full_test = 1'b0;
  logic        adder_ovf = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [1:0]  ctl_wdata = '0;
  logic [15:0] res_lo, res_hi;
  logic [1:0]  err_flags;
  logic        err_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] lo;
    logic [15:0] hi;
    logic        f0;
    string       tag;
  } item_t;
  item_t sb[$];
  logic pend = 1'b0;
  bit m_arm0 = 1'b0, m_flag0 = 1'b0;
  logic [15:0] last_lo, last_hi;

  always #5 clk = ~clk;

  acc_field_select i_acc_field_select (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .acc_valid(acc_valid),
    .sel_code(sel_code), .full_test(full_test), .adder_ovf(adder_ovf),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .res_lo(res_lo),
    .res_hi(res_hi), .err_flags(err_flags), .err_n(err_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: arithmetic on integers, range test by magnitude.
  task automatic ref_calc(input logic [35:0] a, input int sel, input bit tst,
                          output logic [23:0] res, output bit ovf);
    longint v, q, r, t;
    v = longint'(signed'(a));
    if (tst) begin
      q = v * 2; r = 0;
    end else begin
      q = v >>> (sel * 4);
      r = (sel == 0) ? 0 : ((v >>> (sel * 4 - 1)) & 1);
    end
    t   = q + r;
    ovf = (t > 64'sd8388607) || (t < -64'sd8388608);
    res = t[23:0];
  endtask

  task automatic send(logic [35:0] a, int sel, bit tst, string tag);
    item_t it;
    logic [23:0] res;
    bit ovf;
    ref_calc(a, sel, tst, res, ovf);
    m_flag0 = m_flag0 | (m_arm0 & ovf);
    it.lo  = res[15:0];
    it.hi  = {{8{res[23]}}, res[23:16]};
    it.f0  = m_flag0;
    it.tag = tag;
    sb.push_back(it);
    last_lo = it.lo;
    last_hi = it.hi;
    @(negedge clk);
    acc_in = a; sel_code = 2'(sel); full_test = tst; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr(logic [1:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (d[0]) m_arm0 = 1'b1;
    else begin m_arm0 = 1'b0; m_flag0 = 1'b0; end
  endtask

  // Scoreboard monitor
  always @(posedge clk) pend <= acc_valid;
  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 result with empty scoreboard actual=%0h expected=none",
                 {res_hi, res_lo});
      end else begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " lo"}, 32'(res_lo), 32'(it.lo));
        chk({it.tag, " hi"}, 32'(res_hi), 32'(it.hi));
        chk({it.tag, " R6 sel flag"}, 32'(err_flags[0]), 32'(it.f0));
        chk({it.tag, " R10 err_n"}, 32'(err_n), 32'(!(it.f0 || err_flags[1])));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_lo", 32'(res_lo), 0);
    chk("R1 res_hi", 32'(res_hi), 0);
    chk("R1 flags", 32'(err_flags), 0);
    chk("R1 err_n", 32'(err_n), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 windows, R3 rounding, R7 unarmed overflow
    send(36'h0_0012_3456, 0, 1'b0, "R2 code0");
    send(36'hF_FFFF_FFFB, 1, 1'b0, "R3 neg round");
    send(36'h1_2345_6789, 1, 1'b0, "R2 code1");
    send(36'h9_8765_4321, 2, 1'b0, "R2 code2 neg");
    send(36'h7_FFFF_F800, 3, 1'b0, "R3 code3 round up");
    send(36'h0_8000_0000, 0, 1'b0, "R7 unarmed ovf");
    chk("R7 flag stays clear", 32'(err_flags), 0);

    // R11 results held with acc_valid low
    @(negedge clk);
    acc_in = 36'h5_5555_5555; sel_code = 2'd3;
    repeat (2) @(negedge clk);
    chk("R11 lo held", 32'(res_lo), 32'(last_lo));
    chk("R11 hi held", 32'(res_hi), 32'(last_hi));

    // R4 test override, selection code ignored
    send(36'h0_0012_3456, 3, 1'b1, "R4 test pos");
    send(36'hF_FFC0_0001, 1, 1'b1, "R4 test neg");
    send(36'h0_0080_0000, 0, 1'b1, "R4 test ovf unarmed");

    // R6 armed overflow, carry out of rounding wraps (R3)
    wr(2'b01);
    send(36'h0_0001_2340, 2, 1'b0, "R6 armed fits");
    chk("R6 no flag on fit", 32'(err_flags[0]), 0);
    send(36'h0_07FF_FFF8, 1, 1'b0, "R3 carry wrap R6");
    chk("R10 err_n low", 32'(err_n), 0);

    // R9 clear and disarm selector bit
    wr(2'b00);
    chk("R9 sel cleared", 32'(err_flags[0]), 0);
    chk("R9 R10 err_n high", 32'(err_n), 1);
    send(36'h8_0000_0000, 0, 1'b0, "R9 disarmed ovf");

    // R8 adder error, R9 blocked clear
    wr(2'b10);
    @(negedge clk); adder_ovf = 1'b1;
    @(negedge clk);
    chk("R8 adder flag set", 32'(err_flags[1]), 1);
    chk("R10 err_n low adder", 32'(err_n), 0);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 2'b00;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R9 adder clear blocked", 32'(err_flags[1]), 1);
    adder_ovf = 1'b0;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 2'b00;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R9 adder cleared", 32'(err_flags[1]), 0);
    chk("R10 err_n idle", 32'(err_n), 1);
    // disarmed adder bit ignores overflow
    adder_ovf = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 disarmed adder", 32'(err_flags[1]), 0);
    adder_ovf = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule